// File: doc/BRIEF.md
# Cascaded FIFO Slice Ring

This block builds one deep first-in first-out queue out of several identical shallow slices connected in a ring. Every slice has its own storage and its own write and read pointers. At any moment exactly one slice may accept writes, because it holds the write token, and exactly one slice may serve reads, because it holds the read token. The two tokens travel around the ring independently of each other.

When the slice that holds the write token stores a word in its highest location, it raises a one-cycle hand-off pulse toward its neighbour and gives up the token. The neighbour then owns writes, starting at its location zero. Reads hand off in the same way on a separate qualifier line. After reset the slice whose first-load input is low holds both tokens, and every other slice ignores strobes until a token reaches it. The wrapper combines the active-low flags of all slices with an OR, so the composite full or empty flag asserts only when every slice reports that condition. A read is accepted on a clock edge and its data appears one cycle later with a valid strobe.

Top module: `fxp_chain`

## Requirements
- R1: While reset is held and directly after it, full_n_o is 1, empty_n_o is 0 and rd_valid_o is 0.
- R2: Words come out in exactly the order in which they were accepted, including across slice boundaries.
- R3: A write strobe while full_n_o is 0 stores nothing, and the word never appears on the output.
- R4: A read strobe while empty_n_o is 0 is ignored, and rd_valid_o stays 0 in the following cycle.
- R5: A read accepted on a clock edge (rd_en_i high, empty_n_o high) gives rd_valid_o high with the word on rd_data_o during the next cycle only.
- R6: full_n_o is 0 exactly when the ring stores NUM_SLICES*DEPTH words.
- R7: empty_n_o is 0 exactly when the ring stores no word.
- R8: After the last slice fills its highest location, the write token returns to the first slice at location zero. The read token does the same, so the queue keeps its order through every lap of the ring.
- R9: A write and a read accepted on the same edge both take effect, and the stored count stays the same.
- R10: Exactly one slice holds the write token and exactly one holds the read token. A slice gives its token up on the cycle it accesses its highest location, and its neighbour takes the token on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Write word |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DW | Read word, meaningful while rd_valid_o is high |
| rd_valid_o | output | 1 | Read data valid, one cycle after the accepted read |
| full_n_o | output | 1 | Composite full flag, active low |
| empty_n_o | output | 1 | Composite empty flag, active low |

## Verification
A fill run writes more words than one slice holds, up to the full ring capacity and past it, and then drains everything. This shows that each slice hands over write and read ownership at its top location and that a write strobe at capacity is dropped. A read strobe on the empty ring after reset and after the drain shows that an empty read produces no valid strobe. A long pseudo-random phase mixes lone writes, lone reads and simultaneous pairs while the tokens lap the ring several times. This phase separates a correct hand-off and pointer wrap from designs that lose, duplicate or reorder words at slice edges. The bench compares the flags with a reference count on every cycle.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  // token hand-off between neighbouring slices
  typedef struct packed {
    logic wr;
    logic rd;
  } fxp_xfer_t;
endpackage

// File: rtl/fxp_port.sv
module fxp_port #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_ni,
  input  logic          req_i,
  input  logic          ok_i,
  input  logic          xi_i,
  output logic          fire_o,
  output logic [AW-1:0] ptr_o,
  output logic          tok_o,
  output logic          xo_o
);
  logic last;

  assign last   = (ptr_o == AW'(DEPTH - 1));
  assign fire_o = req_i && ok_i && tok_o;
  assign xo_o   = fire_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (fire_o) begin
      ptr_o <= last ? '0 : ptr_o + AW'(1);
    end
  end

  // incoming hand-off wins, so a one-slice ring keeps its token
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_o <= !first_ni;
    end else if (xi_i) begin
      tok_o <= 1'b1;
    end else if (xo_o) begin
      tok_o <= 1'b0;
    end
  end

  p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xo_o |=> (ptr_o == '0));

  p_pass_drops_tok_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xo_o && !xi_i) |=> !tok_o);

  p_idle_ptr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_o |=> $stable(ptr_o));
endmodule

// File: rtl/fxp_slice.sv
module fxp_slice
  import fxp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  fxp_xfer_t     xi_i,
  output fxp_xfer_t     xo_o,
  output logic          full_n_o,
  output logic          empty_n_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_tok_o,
  output logic          rd_tok_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          wr_fire, rd_fire;

  assign full_n_o  = (count != CW'(DEPTH));
  assign empty_n_o = (count != '0);

  fxp_port #(.DEPTH(DEPTH)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_ni(first_ni),
    .req_i   (wr_en_i),
    .ok_i    (full_n_o),
    .xi_i    (xi_i.wr),
    .fire_o  (wr_fire),
    .ptr_o   (wr_ptr),
    .tok_o   (wr_tok_o),
    .xo_o    (xo_o.wr)
  );

  fxp_port #(.DEPTH(DEPTH)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_ni(first_ni),
    .req_i   (rd_en_i),
    .ok_i    (empty_n_o),
    .xi_i    (xi_i.rd),
    .fire_o  (rd_fire),
    .ptr_o   (rd_ptr),
    .tok_o   (rd_tok_o),
    .xo_o    (xo_o.rd)
  );

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count <= '0;
    end else begin
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_fire;
      if (rd_fire) rd_data_o <= mem[rd_ptr];
    end
  end

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_n_o && !rd_fire) |=> $stable(count));
endmodule

// File: rtl/fxp_chain.sv
module fxp_chain
  import fxp_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 8,
  parameter int NUM_SLICES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          full_n_o,
  output logic          empty_n_o
);
  fxp_xfer_t              xo   [NUM_SLICES];
  logic [NUM_SLICES-1:0]  full_n, empty_n, vld, wr_tok, rd_tok;
  logic [DW-1:0]          dat  [NUM_SLICES];

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
    localparam logic FIRST_N = (i == 0) ? 1'b0 : 1'b1;

    fxp_slice #(.DW(DW), .DEPTH(DEPTH)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .first_ni  (FIRST_N),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i),
      .xi_i      (xo[PREV]),
      .xo_o      (xo[i]),
      .full_n_o  (full_n[i]),
      .empty_n_o (empty_n[i]),
      .rd_valid_o(vld[i]),
      .rd_data_o (dat[i]),
      .wr_tok_o  (wr_tok[i]),
      .rd_tok_o  (rd_tok[i])
    );
  end

  // active-low flags: composite asserts only when every slice agrees
  assign full_n_o   = |full_n;
  assign empty_n_o  = |empty_n;
  assign rd_valid_o = |vld;

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (vld[i]) rd_data_o = rd_data_o | dat[i];
    end
  end

  p_one_wr_tok_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_tok) == 1);

  p_one_rd_tok_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_tok) == 1);

  p_one_reader_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld));

  p_rd_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_n_o) |=> rd_valid_o);

  p_idle_no_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && empty_n_o) |=> !rd_valid_o);

  p_full_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_n_o && !rd_en_i) |=> !full_n_o);
endmodule

// File: tb/tb_fxp_chain.sv
module tb_fxp_chain;
  localparam int DW  = 8;
  localparam int DEP = 8;
  localparam int NS  = 3;
  localparam int CAP = DEP * NS;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, full_n, empty_n;

  int checks = 0, fails = 0;
  int m_cnt = 0;
  bit m_vld = 1'b0;
  bit run = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  fxp_chain #(.DW(DW), .DEPTH(DEP), .NUM_SLICES(NS)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .rd_valid_o(rd_valid),
    .full_n_o  (full_n),
    .empty_n_o (empty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // driver: checks flags and valid, then drives one cycle and updates the model
  task automatic step(input bit we, input logic [DW-1:0] wd, input bit re, input string tag);
    bit wacc, racc;
    @(negedge clk);
    chk(full_n == (m_cnt != CAP), {tag, " R6 full_n"}, int'(full_n), int'(m_cnt != CAP));
    chk(empty_n == (m_cnt != 0), {tag, " R7 empty_n"}, int'(empty_n), int'(m_cnt != 0));
    chk(rd_valid == m_vld, {tag, " R5/R4 rd_valid"}, int'(rd_valid), int'(m_vld));
    wr_en = we; wr_data = wd; rd_en = re;
    wacc = we && (m_cnt != CAP);
    racc = re && (m_cnt != 0);
    if (wacc) exp_q.push_back(wd);
    m_vld = racc;
    m_cnt = m_cnt + int'(wacc) - int'(racc);
  endtask

  // monitor: scoreboard compare of every delivered word
  always @(negedge clk) begin
    if (run && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3 unexpected word", int'(rd_data), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R2/R8/R10 order", int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [DW-1:0] seq;
    repeat (3) @(negedge clk);
    chk(full_n == 1'b1, "R1 full_n in reset", int'(full_n), 1);
    chk(empty_n == 1'b0, "R1 empty_n in reset", int'(empty_n), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
    rst_ni = 1'b1;
    run = 1'b1;
    step(0, '0, 0, "R1");

    // R4: read on empty ring
    step(0, '0, 1, "R4");
    step(0, '0, 1, "R4");

    // fill past one slice, up to capacity, then R3 extra writes
    seq = 8'h10;
    for (int i = 0; i < CAP; i++) begin
      step(1, seq, 0, "fill");
      seq++;
    end
    for (int i = 0; i < 3; i++) step(1, 8'hEE, 0, "R3");

    // drain everything and one more empty read
    for (int i = 0; i < CAP; i++) step(0, '0, 1, "drain");
    step(0, '0, 1, "R4");
    step(0, '0, 0, "R4");

    // R9: mixed pattern, tokens lap the ring several times
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit we, re;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      we = (i < 300) ? (lfsr[1:0] != 2'b00) : lfsr[0];
      re = (i < 300) ? lfsr[2] : (lfsr[3:2] != 2'b00);
      step(we, seq, re, "R9");
      if (we) seq++;
    end
    // R8: wrap-around with simultaneous ops on a full ring
    while (m_cnt != CAP) begin
      step(1, seq, 0, "R8");
      seq++;
    end
    for (int i = 0; i < 5; i++) begin
      step(1, seq, 1, "R9");
      seq++;
    end
    while (m_cnt != 0) step(0, '0, 1, "R8");
    step(0, '0, 0, "end");
    step(0, '0, 0, "end");
    chk(exp_q.size() == 0, "R2 words left", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule